// File: doc/BRIEF.md
# NAND Flash Target Command Decoder

This block is the device side of a byte-wide NAND flash interface, used as a stand-in target when a flash host controller is exercised. It samples the chip-enable, command-latch, address-latch, write-strobe and read-strobe lines together with an 8-bit I/O bus on its own system clock. Write-strobe rising edges latch commands, address bytes or data bytes. Read-strobe cycles return identification bytes, a status byte, or bytes from a small internal page buffer. No memory array is modelled. An accepted operation holds the ready/busy line low for a fixed number of clock cycles. A page read serves the page buffer, a program writes into it, and an erase fills it with FFh.

The command state machine only accepts an operation when the setup command, the correct number of address bytes and the matching confirm command arrive in that order. Any other order falls back to idle and does nothing. This guards the buffer against stray strobes. States: IDLE, RD_ADDR, RD_CONF, PG_ADDR, PG_DATA, ER_ADDR, ER_CONF, ID_ADDR and BUSY.

Transitions:
- Command 00h goes to RD_ADDR. So does an address byte arriving in IDLE while read output is selected.
- The fifth address byte moves RD_ADDR to RD_CONF. Command 30h then moves RD_CONF to BUSY.
- 80h goes to PG_ADDR. The fifth address byte moves it to PG_DATA, and 10h moves PG_DATA to BUSY.
- 60h goes to ER_ADDR. The third row byte moves it to ER_CONF, and D0h moves ER_CONF to BUSY.
- 90h goes to ID_ADDR, and one address byte returns it to IDLE.
- Outside BUSY, an unknown command, a misplaced confirm, or a surplus address byte goes to IDLE.
- BUSY returns to IDLE once the busy timer expires.

Top module: `nand_cmd_decoder`

## Requirements
- R1: After reset, rb_n is 1, io_oe is 0, and read output is selected, so an address sequence without a leading 00h starts a read.
- R2: Command 00h, five address bytes and 30h start a read. Afterwards, each read-strobe cycle returns the page-buffer byte at the column pointer, and the rising edge of the read strobe advances the pointer. The pointer starts at the low bits of the first column byte.
- R3: Back-to-back reads may omit 00h: five address bytes followed by 30h start the second read.
- R4: Only 60h, three row bytes and D0h, in that order, erase, which sets every page-buffer byte to FFh. Any other order neither erases nor drives rb_n low.
- R5: After 90h and one address byte, successive read cycles return MAKER_ID, DEVICE_ID, 00h and ORG_ID, then 00h. ID output persists through address bytes until a new command arrives.
- R6: After 70h, the output byte has bit 7 = 1, bit 6 = ready (1 when not busy), bits 5..1 = 0 and bit 0 = fail. Fail is set when a program or erase row address has a bit set at or above ROW_BITS.
- R7: An accepted operation holds rb_n low for exactly BUSY_CYCLES clocks. While busy, every command except 70h is ignored.
- R8: While ce_n is high, io_oe is 0, and write-strobe and read-strobe edges have no effect.
- R9: An unrecognised command byte returns the state machine to IDLE without driving rb_n low.
- R10: Address bytes arrive column low, column high, row 1, row 2, row 3. addr_out = {row3,row2,row1,colhi,collo} is loaded only on an accepted confirm. For an erase, the column bytes read as zero.
- R11: Command 80h, five address bytes, data bytes and 10h write the data into the page buffer from the column pointer upward, then go busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, latches on rising edge |
| re_n | input | 1 | Read strobe, output while low |
| io_in | input | 8 | I/O bus input |
| io_out | output | 8 | I/O bus output value |
| io_oe | output | 1 | I/O output enable |
| rb_n | output | 1 | Ready/busy, low while busy (open-drain style) |
| addr_out | output | 40 | Collected address, loaded on confirm |

## Verification
A status request and the running busy timer can meet in the same cycle: 70h is accepted while BUSY, and the ready bit of the status byte must change in the very cycle that rb_n rises. The bench writes 70h and reads status during a program's busy window, expecting 80h. It then issues 90h, which must be ignored, waits for rb_n to rise, and expects C0h rather than an ID byte. This shows that the status path and the busy timer agree, and that the ignored command did not change the output selection.

// File: rtl/nand_tgt_pkg.sv
package nand_tgt_pkg;

    localparam int ADDR_W = 40;

    localparam logic [7:0] CMD_READ     = 8'h00;
    localparam logic [7:0] CMD_READ_GO  = 8'h30;
    localparam logic [7:0] CMD_PROG     = 8'h80;
    localparam logic [7:0] CMD_PROG_GO  = 8'h10;
    localparam logic [7:0] CMD_ERASE    = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
    localparam logic [7:0] CMD_ID       = 8'h90;
    localparam logic [7:0] CMD_STATUS   = 8'h70;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_ADDR, ST_RD_CONF, ST_PG_ADDR, ST_PG_DATA,
        ST_ER_ADDR, ST_ER_CONF, ST_ID_ADDR, ST_BUSY
    } state_e;

    typedef enum logic [1:0] {
        OUT_DATA, OUT_ID, OUT_STATUS
    } outmode_e;

    typedef struct packed {
        logic       cmd;
        logic       addr;
        logic       data;
        logic       rd_done;
        logic [7:0] byte_v;
    } bus_ev_t;

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler
    import nand_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic [7:0] io_in,
    output bus_ev_t    ev,
    output logic       out_en
);
    logic       ce_q, cle_q, ale_q, we_q, we_d, re_q, re_d;
    logic [7:0] io_q;
    logic       we_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q  <= 1'b1;
            cle_q <= 1'b0;
            ale_q <= 1'b0;
            we_q  <= 1'b1;
            we_d  <= 1'b1;
            re_q  <= 1'b1;
            re_d  <= 1'b1;
            io_q  <= '0;
        end else begin
            ce_q  <= ce_n;
            cle_q <= cle;
            ale_q <= ale;
            we_q  <= we_n;
            we_d  <= we_q;
            re_q  <= re_n;
            re_d  <= re_q;
            io_q  <= io_in;
        end
    end

    assign we_rise    = we_q & ~we_d & ~ce_q;
    assign ev.cmd     = we_rise & cle_q & ~ale_q;
    assign ev.addr    = we_rise & ale_q & ~cle_q;
    assign ev.data    = we_rise & ~ale_q & ~cle_q;
    assign ev.rd_done = re_q & ~re_d & ~ce_q;
    assign ev.byte_v  = io_q;
    assign out_en     = ~ce_q & ~re_q;
endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic                     fill_en,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_data
);
    logic [W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (fill_en)
                mem[i] <= '1;
            else if (wr_en && (int'(wr_idx) == i))
                mem[i] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
    import nand_tgt_pkg::*;
#(
    parameter int         PAGE_BYTES  = 16,
    parameter int         BUSY_CYCLES = 8,
    parameter int         ROW_BITS    = 17,
    parameter logic [7:0] MAKER_ID    = 8'hEC,
    parameter logic [7:0] DEVICE_ID   = 8'hDA,
    parameter logic [7:0] ORG_ID      = 8'h15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              cle,
    input  logic              ale,
    input  logic              we_n,
    input  logic              re_n,
    input  logic [7:0]        io_in,
    output logic [7:0]        io_out,
    output logic              io_oe,
    output logic              rb_n,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int CW    = $clog2(PAGE_BYTES);
    localparam int RB_LO = 16 + ROW_BITS;

    bus_ev_t           ev;
    logic              cmd_stb;
    logic              busy_w;
    state_e            state_q, state_d;
    outmode_e          mode_q;
    logic [ADDR_W-1:0] addr_q, addr_out_q;
    logic [2:0]        acnt_q, pos;
    logic [CW-1:0]     col_q;
    logic [2:0]        idx_q;
    logic              fail_q;
    logic              go_read, go_prog, go_erase, go;
    logic              addr_ok, row_bad;
    logic [7:0]        buf_rd, id_byte;

    nand_bus_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .io_in(io_in), .ev(ev), .out_en(io_oe)
    );

    nand_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(go), .busy(busy_w)
    );

    nand_page_buf #(.DEPTH(PAGE_BYTES), .W(8)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ev.data && state_q == ST_PG_DATA), .wr_idx(col_q),
        .wr_data(ev.byte_v), .fill_en(go_erase),
        .rd_idx(col_q), .rd_data(buf_rd)
    );

    assign cmd_stb = ev.cmd;
    assign go      = go_read | go_prog | go_erase;
    assign row_bad = |addr_q[ADDR_W-1:RB_LO];
    assign pos     = (state_q == ST_IDLE)    ? 3'd0 :
                     (state_q == ST_ER_ADDR) ? acnt_q + 3'd2 : acnt_q;
    assign addr_ok = (state_q == ST_RD_ADDR) || (state_q == ST_PG_ADDR) ||
                     (state_q == ST_ER_ADDR) ||
                     (state_q == ST_IDLE && mode_q == OUT_DATA);

    // next-state logic
    always_comb begin
        state_d  = state_q;
        go_read  = 1'b0;
        go_prog  = 1'b0;
        go_erase = 1'b0;
        if (state_q == ST_BUSY) begin
            if (!busy_w) state_d = ST_IDLE;
        end else if (cmd_stb) begin
            unique case (ev.byte_v)
                CMD_READ:  state_d = ST_RD_ADDR;
                CMD_PROG:  state_d = ST_PG_ADDR;
                CMD_ERASE: state_d = ST_ER_ADDR;
                CMD_ID:    state_d = ST_ID_ADDR;
                CMD_STATUS: state_d = state_q;
                CMD_READ_GO: begin
                    state_d = (state_q == ST_RD_CONF) ? ST_BUSY : ST_IDLE;
                    go_read = (state_q == ST_RD_CONF);
                end
                CMD_PROG_GO: begin
                    state_d = (state_q == ST_PG_DATA) ? ST_BUSY : ST_IDLE;
                    go_prog = (state_q == ST_PG_DATA);
                end
                CMD_ERASE_GO: begin
                    state_d  = (state_q == ST_ER_CONF) ? ST_BUSY : ST_IDLE;
                    go_erase = (state_q == ST_ER_CONF);
                end
                default: state_d = ST_IDLE;
            endcase
        end else if (ev.addr) begin
            unique case (state_q)
                ST_IDLE:    if (mode_q == OUT_DATA) state_d = ST_RD_ADDR;
                ST_RD_ADDR: if (acnt_q == 3'd4) state_d = ST_RD_CONF;
                ST_PG_ADDR: if (acnt_q == 3'd4) state_d = ST_PG_DATA;
                ST_ER_ADDR: if (acnt_q == 3'd2) state_d = ST_ER_CONF;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            mode_q     <= OUT_DATA;
            addr_q     <= '0;
            addr_out_q <= '0;
            acnt_q     <= '0;
            col_q      <= '0;
            idx_q      <= '0;
            fail_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cmd_stb && ev.byte_v == CMD_STATUS) begin
                mode_q <= OUT_STATUS;
            end else if (cmd_stb && state_q != ST_BUSY) begin
                acnt_q <= '0;
                if (ev.byte_v == CMD_ID) begin
                    mode_q <= OUT_ID;
                    idx_q  <= '0;
                end else if (ev.byte_v == CMD_READ || ev.byte_v == CMD_PROG ||
                             ev.byte_v == CMD_ERASE) begin
                    mode_q <= OUT_DATA;
                end
                if (ev.byte_v == CMD_ERASE) addr_q <= '0;
                if (go) addr_out_q <= addr_q;
                if (go_prog || go_erase) fail_q <= row_bad;
                if (go_read) mode_q <= OUT_DATA;
            end else if (ev.addr && addr_ok) begin
                addr_q[{pos, 3'b000} +: 8] <= ev.byte_v;
                acnt_q <= (state_q == ST_IDLE) ? 3'd1 : acnt_q + 3'd1;
                if (pos == 3'd0) col_q <= ev.byte_v[CW-1:0];
            end else if (ev.data && state_q == ST_PG_DATA) begin
                col_q <= col_q + 1'b1;
            end else if (ev.rd_done && state_q != ST_BUSY) begin
                if (mode_q == OUT_DATA)
                    col_q <= col_q + 1'b1;
                else if (mode_q == OUT_ID && idx_q != 3'd4)
                    idx_q <= idx_q + 3'd1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (idx_q)
            3'd0:    id_byte = MAKER_ID;
            3'd1:    id_byte = DEVICE_ID;
            3'd3:    id_byte = ORG_ID;
            default: id_byte = 8'h00;
        endcase
        unique case (mode_q)
            OUT_ID:     io_out = id_byte;
            OUT_STATUS: io_out = {1'b1, ~busy_w, 5'b00000, fail_q};
            default:    io_out = buf_rd;
        endcase
    end

    assign rb_n     = ~busy_w;
    assign addr_out = addr_out_q;
endmodule

// File: rtl/nand_cmd_decoder_chk.sv
module nand_cmd_decoder_chk
    import nand_tgt_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              io_oe,
    input logic              rb_n,
    input logic [ADDR_W-1:0] addr_out,
    input outmode_e          mode_q,
    input logic              cmd_stb
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     low_cnt <= '0;
        else if (!rb_n) low_cnt <= low_cnt + 16'd1;
        else            low_cnt <= '0;
    end

    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n && $past(ce_n) |-> !io_oe);

    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_n) |-> low_cnt == 16'(BUSY_CYCLES));

    p_addr_on_confirm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_out != $past(addr_out)) |-> $fell(rb_n));

    p_id_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == OUT_ID && !$past(cmd_stb)) |-> mode_q == OUT_ID);

    p_busy_needs_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_n) |-> $past(cmd_stb));
endmodule

bind nand_cmd_decoder nand_cmd_decoder_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .io_oe(io_oe), .rb_n(rb_n),
    .addr_out(addr_out), .mode_q(mode_q), .cmd_stb(cmd_stb)
);

// File: tb/nand_cmd_decoder_test.sv
`timescale 1ns/1ps
module nand_cmd_decoder_test;
    localparam int BUSY = 24;

    logic        clk = 0, rst_n = 0;
    logic        ce_n = 1, cle = 0, ale = 0, we_n = 1, re_n = 1;
    logic [7:0]  io_in = 0;
    logic [7:0]  io_out;
    logic        io_oe, rb_n;
    logic [39:0] addr_out;

    int tests = 0, fails = 0;
    bit done = 0, mon_en = 0, want_oe = 0;

    always #2 clk = ~clk;

    nand_cmd_decoder #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .io_in(io_in), .io_out(io_out),
        .io_oe(io_oe), .rb_n(rb_n), .addr_out(addr_out)
    );

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock reference for the output enable (R8): one sampling stage
    always @(posedge clk) want_oe <= !ce_n && !re_n;
    always @(negedge clk) if (mon_en) chk("R8 io_oe per clock", io_oe, want_oe);

    task automatic bw(input logic c, input logic a, input logic [7:0] b, input logic ce = 0);
        @(negedge clk);
        cle = c; ale = a; io_in = b; ce_n = ce; we_n = 0;
        repeat (2) @(negedge clk);
        we_n = 1;
        repeat (2) @(negedge clk);
        cle = 0; ale = 0; ce_n = 0;
    endtask

    task automatic cmd(input logic [7:0] b); bw(1, 0, b); endtask
    task automatic adr(input logic [7:0] b); bw(0, 1, b); endtask
    task automatic din(input logic [7:0] b, input logic ce = 0); bw(0, 0, b, ce); endtask

    task automatic adr5(input logic [7:0] c0, input logic [7:0] r0, input logic [7:0] r2);
        adr(c0); adr(8'h00); adr(r0); adr(8'h00); adr(r2);
    endtask

    task automatic rd(output logic [7:0] d, output logic oe, input logic ce = 0);
        @(negedge clk);
        ce_n = ce; re_n = 0;
        repeat (2) @(negedge clk);
        d = io_out; oe = io_oe;
        re_n = 1;
        repeat (2) @(negedge clk);
        ce_n = 0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!rb_n && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] exp);
        logic [7:0] d; logic oe;
        rd(d, oe);
        chk(req, d, exp);
        chk({req, " oe"}, oe, 1'b1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] d;
        logic oe;
        repeat (4) @(negedge clk);
        rst_n = 1;
        ce_n = 0;
        @(negedge clk);
        mon_en = 1;
        // R1 reset state
        chk("R1 rb_n after reset", rb_n, 1'b1);
        chk("R1 io_oe after reset", io_oe, 1'b0);

        // R11 program col 2 row 5
        cmd(8'h80); adr5(8'h02, 8'h05, 8'h00);
        din(8'hA0); din(8'hA1); din(8'hA2); din(8'hA3);
        cmd(8'h10);
        wait_ready(n);
        chk("R7 program busy length", n, BUSY);
        chk("R10 program addr_out", addr_out, 40'h0000050002);
        // R6 status pass
        cmd(8'h70);
        rd_chk("R6 status ready pass", 8'hC0);

        // R2 read
        cmd(8'h00); adr5(8'h02, 8'h05, 8'h00); cmd(8'h30);
        wait_ready(n);
        chk("R2 read busy length", n, BUSY);
        rd_chk("R2 byte0", 8'hA0);
        rd_chk("R2 byte1", 8'hA1);
        rd_chk("R11 byte2", 8'hA2);

        // R3 read without 00h
        adr5(8'h03, 8'h07, 8'h00); cmd(8'h30);
        wait_ready(n);
        chk("R3 busy length", n, BUSY);
        chk("R10 read addr_out", addr_out, 40'h0000070003);
        rd_chk("R3 first byte", 8'hA1);

        // R5 identification
        cmd(8'h90); adr(8'h00);
        rd_chk("R5 maker", 8'hEC);
        adr5(8'h02, 8'h05, 8'h00);
        chk("R5 addr no busy", rb_n, 1'b1);
        rd_chk("R5 device after address bytes", 8'hDA);
        rd_chk("R5 third", 8'h00);
        rd_chk("R5 fourth", 8'h15);
        rd_chk("R5 fifth", 8'h00);

        // R4 incomplete erase sequences
        cmd(8'h60); adr(8'h00); adr(8'h01); cmd(8'hD0);
        chk("R4 two rows no busy", rb_n, 1'b1);
        cmd(8'hD0);
        chk("R4 lone confirm no busy", rb_n, 1'b1);
        cmd(8'h60); adr(8'h00); adr(8'h01); adr(8'h00); adr(8'h00); cmd(8'hD0);
        chk("R4 extra address no busy", rb_n, 1'b1);
        cmd(8'h00); adr5(8'h02, 8'h05, 8'h00); cmd(8'h30);
        wait_ready(n);
        rd_chk("R4 buffer intact", 8'hA0);

        // R4 proper erase
        cmd(8'h60); adr(8'h00); adr(8'h01); adr(8'h00); cmd(8'hD0);
        wait_ready(n);
        chk("R4 erase busy length", n, BUSY);
        chk("R10 erase addr_out", addr_out, 40'h0001000000);
        cmd(8'h00); adr5(8'h02, 8'h05, 8'h00); cmd(8'h30);
        wait_ready(n);
        rd_chk("R4 erased byte", 8'hFF);

        // R6 fail bit from out-of-range row
        cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h02); cmd(8'hD0);
        wait_ready(n);
        cmd(8'h70);
        rd_chk("R6 status fail", 8'hC1);

        // R9 unrecognised command
        cmd(8'h00); adr5(8'h02, 8'h05, 8'h00);
        cmd(8'h55);
        chk("R9 no busy after unknown", rb_n, 1'b1);
        cmd(8'h30);
        chk("R9 confirm after unknown no busy", rb_n, 1'b1);

        // R8 chip enable high ignores strobes
        cmd(8'h80); adr5(8'h08, 8'h00, 8'h00);
        din(8'h11); din(8'h22, 1'b1); din(8'h33);
        cmd(8'h10);
        wait_ready(n);
        cmd(8'h00); adr5(8'h08, 8'h00, 8'h00); cmd(8'h30);
        wait_ready(n);
        rd_chk("R8 first data", 8'h11);
        rd(d, oe, 1'b1);
        chk("R8 oe released", oe, 1'b0);
        rd_chk("R8 data skipped while deselected", 8'h33);

        // R7 status during busy and ignored command
        cmd(8'h80); adr5(8'h00, 8'h01, 8'h00); din(8'h5A); cmd(8'h10);
        chk("R7 busy asserted", rb_n, 1'b0);
        cmd(8'h70);
        rd_chk("R7 status busy", 8'h80);
        cmd(8'h90);
        wait_ready(n);
        rd_chk("R7 status after ready, id ignored", 8'hC0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule